// File: doc/BRIEF.md
# Asynchronous Event Deadline Detector

This block measures whether an event signal, which has no timing relation to the local clock, rises before a fixed number of clock edges have gone by since the detector was armed. A one-cycle start pulse arms it. From then on it counts clock edges. When the window closes with no event, it raises a single-cycle miss flag.

The event is never combined with the clock. A sticky register catches its rising edge asynchronously, so even a pulse much shorter than a clock period is kept. A two-flop synchronizer then carries the caught state into the clock domain, and all decisions are made there. The synchronized capture also drives an event-seen output, which stays high until the next start.

Edges are numbered from the start edge, which is edge 0. The window length is `DEADLINE` edges (default 4). An event is counted when its rising edge comes strictly before edge `DEADLINE`. The synchronizer delays the decision, so the miss flag rises after edge `DEADLINE + 2`.

Top module: `deadline_watch`

## Requirements
- R1: After synchronous reset, `miss_o` and `seen_o` are low. Without a start pulse, no miss pulse is ever produced.
- R2: A start pulse sampled at a clock edge makes that edge edge 0 of a new window. It clears the event capture and the synchronizer, so `seen_o` is low in the cycle after the start edge. A start that arrives during a window restarts the timing.
- R3: If no event is counted in a window, `miss_o` is high for exactly the cycle that follows edge `DEADLINE + 2`. In every other cycle it is low.
- R4: An event whose rising edge falls between edge k-1 and edge k is counted when k <= `DEADLINE`, and then no miss pulse occurs. When k > `DEADLINE` the event is not counted, and the miss pulse still occurs.
- R5: An event pulse much shorter than a clock period, lying entirely between two clock edges, is still captured.
- R6: `seen_o` rises after edge k+1 for an event rising between edge k-1 and edge k. It then stays high until the next start edge.
- R7: At most one miss pulse occurs per window. After the window closes, the counter holds and no further pulse comes until the next start.
- R8: If the event is still high at the start edge, the capture cannot be cleared. The event then counts as arriving in the first cycle: `seen_o` rises after edge 2 and no miss pulse occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | One-cycle pulse that arms a new measurement window |
| evt_async_i | input | 1 | Event input, asynchronous to `clk`, active on its rising edge |
| miss_o | output | 1 | One-cycle flag: the window closed with no event counted |
| seen_o | output | 1 | Synchronized event capture, held until the next start |

## Verification
The bench sweeps the event's arrival over every cycle slot from the first edge to well past the deadline, and also runs a window with no event. Each slot gets a short pulse that lies between two edges. In every cycle it compares both outputs against arrival-slot arithmetic. An off-by-one in the synchronizer depth or in the counter limit would move the boundary between slot `DEADLINE` and slot `DEADLINE + 1`, or shift the cycle of the flag. A capture register clocked only by `clk` would lose every short pulse. Separate runs restart a window midway, hold the event high across the start edge, and watch for a second miss pulse after the window closes. These catch a start that fails to reset the timing, a clear that races the asynchronous set, and a counter that does not saturate.

// File: rtl/dlw_pkg.sv
package dlw_pkg;

    // Phase of the measurement window
    typedef enum logic [1:0] {
        WIN_IDLE = 2'd0,
        WIN_RUN  = 2'd1,
        WIN_DONE = 2'd2
    } win_state_e;

endpackage

// File: rtl/dlw_capture.sv
// Sticky capture: set asynchronously by the event's rising edge,
// cleared synchronously only when the event is low (set has priority).
module dlw_capture (
    input  logic clk,
    input  logic evt_i,
    input  logic clr_i,
    output logic cap_o
);
    logic cap_q;

    always_ff @(posedge clk or posedge evt_i) begin
        if (evt_i) begin
            cap_q <= 1'b1;
        end else if (clr_i) begin
            cap_q <= 1'b0;
        end
    end

    assign cap_o = cap_q;
endmodule

// File: rtl/dlw_sync.sv
// Multi-flop synchronizer with a synchronous clear.
module dlw_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic clr_i,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] sh_d, sh_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb begin
                sh_d = clr_i ? 1'b0 : d_i;
            end
        end else begin : g_many
            always_comb begin
                sh_d = clr_i ? '0 : {sh_q[STAGES-2:0], d_i};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        sh_q <= sh_d;
    end

    assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/dlw_window.sv
// Window counter and miss flag, two-process style.
module dlw_window
    import dlw_pkg::*;
#(
    parameter int DEADLINE = 4,
    parameter int STAGES   = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic seen_i,
    output logic miss_o
);
    localparam int LAST = DEADLINE + STAGES - 1;
    localparam int CW   = $clog2(LAST + 1);

    typedef struct packed {
        win_state_e    st;
        logic [CW-1:0] cnt;
        logic          miss;
    } win_t;

    win_t win_d, win_q;

    always_comb begin
        win_d      = win_q;
        win_d.miss = 1'b0;
        case (win_q.st)
            WIN_RUN: begin
                if (win_q.cnt == CW'(LAST)) begin
                    win_d.miss = ~seen_i;
                    win_d.st   = WIN_DONE;
                end else begin
                    win_d.cnt = win_q.cnt + 1'b1;
                end
            end
            default: ;
        endcase
        if (start_i) begin
            win_d.st   = WIN_RUN;
            win_d.cnt  = '0;
            win_d.miss = 1'b0;
        end
        if (rst) begin
            win_d.st   = WIN_IDLE;
            win_d.cnt  = '0;
            win_d.miss = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        win_q <= win_d;
    end

    assign miss_o = win_q.miss;
endmodule

// File: rtl/deadline_watch.sv
module deadline_watch #(
    parameter int DEADLINE = 4,
    parameter int STAGES   = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic evt_async_i,
    output logic miss_o,
    output logic seen_o
);
    logic clr_w, cap_w, seen_w;

    assign clr_w = rst | start_i;

    dlw_capture u_cap (
        .clk   (clk),
        .evt_i (evt_async_i),
        .clr_i (clr_w),
        .cap_o (cap_w)
    );

    dlw_sync #(.STAGES(STAGES)) u_sync (
        .clk   (clk),
        .clr_i (clr_w),
        .d_i   (cap_w),
        .q_o   (seen_w)
    );

    dlw_window #(.DEADLINE(DEADLINE), .STAGES(STAGES)) u_win (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .seen_i  (seen_w),
        .miss_o  (miss_o)
    );

    assign seen_o = seen_w;
endmodule

// File: rtl/dlw_checker.sv
module dlw_checker #(
    parameter int DEADLINE = 4,
    parameter int STAGES   = 2
) (
    input logic clk,
    input logic rst,
    input logic start_i,
    input logic miss_o,
    input logic seen_o
);
    localparam int FIRE = DEADLINE + STAGES;
    localparam int SW   = $clog2(FIRE + 2);

    logic [SW-1:0] since_q;
    logic          armed_q;

    // Independent edge count since the last start edge, saturating
    always_ff @(posedge clk) begin
        if (rst) begin
            since_q <= '0;
            armed_q <= 1'b0;
        end else if (start_i) begin
            since_q <= '0;
            armed_q <= 1'b1;
        end else if (since_q != SW'(FIRE + 1)) begin
            since_q <= since_q + 1'b1;
        end
    end

    AST_MISS_NEEDS_START: assert property (@(posedge clk) disable iff (rst)
        miss_o |-> armed_q) else $error("miss without start"); // R1
    AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (!seen_o && !miss_o)) else $error("start did not clear"); // R2
    AST_MISS_TIMING: assert property (@(posedge clk) disable iff (rst)
        miss_o |-> (since_q == SW'(FIRE))) else $error("miss at wrong edge"); // R3
    AST_MISS_SINGLE: assert property (@(posedge clk) disable iff (rst)
        miss_o |=> !miss_o) else $error("miss longer than one cycle"); // R7
    AST_SEEN_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (seen_o && !start_i) |=> seen_o) else $error("seen dropped"); // R6
    AST_MISS_NOT_SEEN: assert property (@(posedge clk) disable iff (rst)
        $rose(miss_o) |-> !$past(seen_o)) else $error("miss after event seen"); // R4
endmodule

bind deadline_watch dlw_checker #(.DEADLINE(DEADLINE), .STAGES(STAGES)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .miss_o  (miss_o),
    .seen_o  (seen_o)
);

// File: tb/sim_deadline_watch.sv
`timescale 1ns/1ps
module sim_deadline_watch;
    localparam int D  = 4;
    localparam int S  = 2;
    localparam int NC = D + S + 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 1'b0;
    logic evt = 1'b0;
    logic miss_o, seen_o;
    int   checks = 0;
    int   errors = 0;

    always #10 clk = ~clk;

    deadline_watch #(.DEADLINE(D), .STAGES(S)) u0 (
        .clk (clk), .rst (rst), .start_i (start_i),
        .evt_async_i (evt), .miss_o (miss_o), .seen_o (seen_o)
    );

    task automatic chk(input logic act, input logic exp, input string req, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, what, act, exp, $time);
        end
    endtask

    task automatic do_start();
        start_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        chk(seen_o, 1'b0, "R2", "seen after start edge");
        chk(miss_o, 1'b0, "R2", "miss after start edge");
    endtask

    // k = 0: no event; else short pulse between edge k-1 and edge k
    task automatic run_window(input int k);
        do_start();
        for (int j = 1; j <= NC; j++) begin
            if (k == j) begin
                #2 evt = 1'b1;   // R5: 3 ns pulse
                #3 evt = 1'b0;
            end
            @(posedge clk);
            @(negedge clk);
            chk(miss_o, (j == D + S) && (k == 0 || k > D), (k > D || k == 0) ? "R3" : "R4", $sformatf("miss k=%0d j=%0d", k, j));
            chk(seen_o, (k != 0) && (j >= k + 1), "R6", $sformatf("seen k=%0d j=%0d", k, j));
        end
    endtask

    initial begin
        #(20 * 5000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk(miss_o, 1'b0, "R1", "miss after reset");
        chk(seen_o, 1'b0, "R1", "seen after reset");
        for (int j = 0; j < NC; j++) begin
            @(negedge clk);
            chk(miss_o, 1'b0, "R1", "miss while idle");
        end

        // R3 R4 R5 R6 R7: sweep arrival slot, including no event
        for (int k = 0; k <= D + S + 2; k++) begin
            run_window(k);
        end

        // R2: restart in the middle of a window, no event
        do_start();
        for (int j = 1; j <= 3; j++) begin
            @(negedge clk);
            chk(miss_o, 1'b0, "R2", "miss before restart");
        end
        run_window(0);

        // R8: event held high across the start edge
        @(negedge clk);
        evt = 1'b1;
        @(negedge clk);
        do_start();
        for (int j = 1; j <= NC; j++) begin
            if (j == 3) evt = 1'b0;
            @(posedge clk);
            @(negedge clk);
            chk(miss_o, 1'b0, "R8", $sformatf("miss held event j=%0d", j));
            chk(seen_o, j >= 2, "R8", $sformatf("seen held event j=%0d", j));
        end

        // R7: no further pulse long after the window closed
        run_window(0);
        for (int j = 0; j < 3 * NC; j++) begin
            @(negedge clk);
            chk(miss_o, 1'b0, "R7", "miss after window closed");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule